// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Status

This block keeps the interrupt status of a two-channel disk controller and drives a single shared, level-sensitive interrupt line. Each channel's status flag appears at two places in configuration space. One is a per-channel alias byte. The other is a main mode byte that holds both channels' flags and their block bits. The two copies of a flag are stored in separate flops. The update rules keep them equal whichever location software clears.

A channel's flag follows its request input when that input changes level. Software clears a flag by writing one to either copy. Software can never set a flag. The interrupt line is the OR over channels of "flag set and not blocked". A read-only control byte reports which channels are enabled.

Configuration access is a 32-bit port that is byte-addressed and dword-aligned, with four byte enables. A write takes effect on the clock edge where `cfg_wr_i` is sampled high. Read data is combinational from `cfg_addr_i`.

Top module: `irq_mirror_top`

## Requirements
- R1: After reset both flags and both block bits are 0 and `irq_o` is low. Dword 0x50, 0x54 and 0x70 read 0, except for the control byte.
- R2: A rising request on channel n sets both copies of flag n at the first clock edge that samples the new level.
- R3: A falling request on channel n clears both copies of flag n at the first clock edge that samples the new level.
- R4: Clearing through the alias copies clears both copies of a flag. Channel 0's alias is byte 0x50 bit 2 (dword 0x50, lane 0, data bit 2). Channel 1's alias is byte 0x57 bit 4 (dword 0x54, lane 3, data bit 28).
- R5: Clearing through the main byte 0x71 clears both copies of a flag. Channel 0 uses bit 2 and channel 1 uses bit 3 (dword 0x70, lane 1, data bits 10 and 11).
- R6: Writing zero to a flag position does not change the flag. A write whose byte lane is disabled does not change the flag either.
- R7: `irq_o` is high exactly when some channel has its flag set and its block bit clear.
- R8: Block bits sit at byte 0x71 bit 4 (channel 0) and bit 5 (channel 1), which are data bits 12 and 13. A plain write with lane 1 enabled loads them. They read back. They gate `irq_o` without changing the flags.
- R9: If a flag is set by a request edge and cleared by a write in the same cycle, the set wins.
- R10: A request that stays high does not set its flag again after software has cleared it.
- R11: The main and alias copies of each flag are equal in every cycle.
- R12: Control byte 0x51 (dword 0x50, lane 1) reads bit 2 = 1. It reads bit 3 = `SECONDARY_EN`. All its other bits read 0, and writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 2 | Per-channel interrupt request levels |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address (dword-aligned use) |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for the dword at `cfg_addr_i` |
| irq_o | output | 1 | Shared level interrupt |

## Verification
The checker examines four things on every cycle. The two copies of each flag must agree. A flag may rise only after its request was high. Request edges must reach both copies one cycle later. The interrupt line must obey the block gating. Other rules can only be shown by the bench's scenarios, because they depend on what was written at which address and lane: zero writes and disabled lanes leaving flags alone, set winning over a simultaneous clear, a held request not re-setting a cleared flag, and the control byte's read-only value.

// File: rtl/irq_mirror_pkg.sv
// Package: constants and helpers shared by the mirrored interrupt status logic.
// Assumes exactly two channels; the register offsets below are fixed by the
// software-visible layout.
package irq_mirror_pkg;
    localparam int NCH          = 2;
    localparam int OFS_CTRL     = 'h51;
    localparam int CTRL_EN_BASE = 2;
    localparam int OFS_MAIN     = 'h71;
    localparam int MAIN_ST_BASE = 2;
    localparam int MAIN_BK_BASE = 4;

    // Byte offset of the alias copy for a channel.
    function automatic int alias_ofs(input int ch);
        return (ch == 0) ? 'h50 : 'h57;
    endfunction

    // Bit position of the alias copy inside its byte.
    function automatic int alias_bit(input int ch);
        return (ch == 0) ? 2 : 4;
    endfunction

    // Decoded write strobes for the status logic.
    typedef struct packed {
        logic [NCH-1:0] clr_main;
        logic [NCH-1:0] clr_alias;
        logic           blk_we;
        logic [NCH-1:0] blk_val;
    } wr_strb_t;
endpackage

// File: rtl/irq_cfg_decode.sv
// Module: turns a byte-enabled configuration write into per-channel clear
// strobes and a block-bit load. Assumes the address is a byte address of
// which only the dword part selects; lanes are picked by the byte enables.
module irq_cfg_decode
    import irq_mirror_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output wr_strb_t            strb
);
    localparam int BEW    = DATA_W / 8;
    localparam int LANE_W = $clog2(BEW);

    // True when the write covers the byte at offset ofs.
    function automatic logic byte_hit(input int ofs);
        logic [ADDR_W-1:0] o;
        o = ADDR_W'(ofs);
        return cfg_wr && (cfg_addr[ADDR_W-1:LANE_W] == o[ADDR_W-1:LANE_W])
               && cfg_be[o[LANE_W-1:0]];
    endfunction

    // Data bit at position b of the byte at offset ofs.
    function automatic logic byte_bit(input int ofs, input int b);
        logic [ADDR_W-1:0] o;
        o = ADDR_W'(ofs);
        return cfg_wdata[int'(o[LANE_W-1:0]) * 8 + b];
    endfunction

    // Per-channel write-one-to-clear strobes for both copies.
    always_comb begin
        strb = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            strb.clr_alias[ch] = byte_hit(alias_ofs(ch)) && byte_bit(alias_ofs(ch), alias_bit(ch));
            strb.clr_main[ch]  = byte_hit(OFS_MAIN) && byte_bit(OFS_MAIN, MAIN_ST_BASE + ch);
            strb.blk_val[ch]   = byte_bit(OFS_MAIN, MAIN_BK_BASE + ch);
        end
        strb.blk_we = byte_hit(OFS_MAIN);
    end
endmodule

// File: rtl/irq_mirror_pair.sv
// Module: one channel's status flag, held as two separately registered
// copies. Assumes req is synchronous to clk. A request level change loads
// the level into both copies; otherwise a clear from either copy's address
// clears both. A set from a request edge beats a simultaneous clear.
module irq_mirror_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr_main,
    input  logic clr_alias,
    output logic st_main,
    output logic st_alias
);
    logic req_q;
    logic chg;
    logic clr_any;

    assign chg     = req ^ req_q;
    assign clr_any = clr_main | clr_alias;

    // Remember the last sampled request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    // Main copy: follows request edges, cleared by either location.
    always_ff @(posedge clk) begin
        if (!rst_n)       st_main <= 1'b0;
        else if (chg)     st_main <= req;
        else if (clr_any) st_main <= 1'b0;
    end

    // Alias copy: mirrored from the same events, held in its own flop.
    always_ff @(posedge clk) begin
        if (!rst_n)       st_alias <= 1'b0;
        else if (chg)     st_alias <= req;
        else if (clr_any) st_alias <= 1'b0;
    end
endmodule

// File: rtl/irq_combine.sv
// Module: ORs the unblocked channel flags into the shared level interrupt.
// Assumes flags and blocks are registered, so the output is glitch-free
// relative to clk.
module irq_combine #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] st,
    input  logic [NCH-1:0] blk,
    output logic           irq
);
    // Level output re-evaluated whenever any flag or block changes.
    always_comb irq = |(st & ~blk);
endmodule

// File: rtl/irq_mirror_top.sv
// Module: top of the mirrored interrupt status logic. Holds the block bits,
// instantiates one mirrored flag pair per channel and builds read data.
// Assumes a dword-wide configuration port with byte enables and a
// combinational read of the addressed dword.
module irq_mirror_top
    import irq_mirror_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter bit SECONDARY_EN  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          req_i,
    input  logic                cfg_wr_i,
    input  logic [ADDR_W-1:0]   cfg_addr_i,
    input  logic [DATA_W/8-1:0] cfg_be_i,
    input  logic [DATA_W-1:0]   cfg_wdata_i,
    output logic [DATA_W-1:0]   cfg_rdata_o,
    output logic                irq_o
);
    localparam int BEW    = DATA_W / 8;
    localparam int LANE_W = $clog2(BEW);
    localparam logic [7:0] CTRL_VAL = 8'((1 << CTRL_EN_BASE) |
                                         (int'(SECONDARY_EN) << (CTRL_EN_BASE + 1)));

    wr_strb_t       strb;
    logic [NCH-1:0] st_main;
    logic [NCH-1:0] st_alias;
    logic [NCH-1:0] blk_q;

    irq_cfg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
        .cfg_wr    (cfg_wr_i),
        .cfg_addr  (cfg_addr_i),
        .cfg_be    (cfg_be_i),
        .cfg_wdata (cfg_wdata_i),
        .strb      (strb)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        irq_mirror_pair pair_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_i[ch]),
            .clr_main  (strb.clr_main[ch]),
            .clr_alias (strb.clr_alias[ch]),
            .st_main   (st_main[ch]),
            .st_alias  (st_alias[ch])
        );
    end

    // Block bits: plain read/write in the main byte.
    always_ff @(posedge clk) begin
        if (!rst_n)           blk_q <= '0;
        else if (strb.blk_we) blk_q <= strb.blk_val;
    end

    irq_combine #(.NCH(NCH)) comb_i (
        .st  (st_main),
        .blk (blk_q),
        .irq (irq_o)
    );

    // True when the read address selects the dword holding byte ofs.
    function automatic logic rd_sel(input int ofs);
        logic [ADDR_W-1:0] o;
        o = ADDR_W'(ofs);
        return cfg_addr_i[ADDR_W-1:LANE_W] == o[ADDR_W-1:LANE_W];
    endfunction

    // Bit index in the data word of bit b of the byte at offset ofs.
    function automatic int rd_pos(input int ofs, input int b);
        logic [ADDR_W-1:0] o;
        o = ADDR_W'(ofs);
        return int'(o[LANE_W-1:0]) * 8 + b;
    endfunction

    // Read data: place every visible bit at its byte lane.
    always_comb begin
        cfg_rdata_o = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (rd_sel(alias_ofs(ch)))
                cfg_rdata_o[rd_pos(alias_ofs(ch), alias_bit(ch))] = st_alias[ch];
            if (rd_sel(OFS_MAIN)) begin
                cfg_rdata_o[rd_pos(OFS_MAIN, MAIN_ST_BASE + ch)] = st_main[ch];
                cfg_rdata_o[rd_pos(OFS_MAIN, MAIN_BK_BASE + ch)] = blk_q[ch];
            end
        end
        if (rd_sel(OFS_CTRL))
            for (int b = 0; b < 8; b++)
                cfg_rdata_o[rd_pos(OFS_CTRL, b)] = CTRL_VAL[b];
    end
endmodule

// File: rtl/irq_mirror_chk.sv
// Module: assertion checker bound to the top; observes request inputs, both
// flag copies, block bits and the interrupt line.
module irq_mirror_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_i,
    input logic [1:0] st_main,
    input logic [1:0] st_alias,
    input logic [1:0] blk,
    input logic       irq_o
);
    // R11: both copies agree
    a_r11_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
        st_main == st_alias);

    // R2: rising request sets the flag one edge later
    a_r2_rise_sets0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_i[0]) |=> st_main[0]);
    a_r2_rise_sets1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_i[1]) |=> st_alias[1]);

    // R3: falling request clears the flag one edge later
    a_r3_fall_clears0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_i[0]) |=> !st_alias[0]);
    a_r3_fall_clears1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_i[1]) |=> !st_main[1]);

    // R6: a flag can only rise after its request was high
    a_r6_no_sw_set0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_main[0]) |-> $past(req_i[0]));
    a_r6_no_sw_set1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_main[1]) |-> $past(req_i[1]));

    // R7: blocked channels never raise the line; an unblocked flag does
    a_r7_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (blk == 2'b11) |-> !irq_o);
    a_r7_unblocked_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_alias[0] && !blk[0]) || (st_alias[1] && !blk[1])) |-> irq_o);
endmodule

bind irq_mirror_top irq_mirror_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .st_main  (st_main),
    .st_alias (st_alias),
    .blk      (blk_q),
    .irq_o    (irq_o)
);

// File: tb/irq_mirror_top_tb_top.sv
// Bench: directed scenarios, one task each, self-checking at negedges.
module irq_mirror_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req = 2'b00;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [3:0]  be = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    irq_mirror_top dut_i (
        .clk (clk), .rst_n (rst_n), .req_i (req), .cfg_wr_i (wr),
        .cfg_addr_i (addr), .cfg_be_i (be), .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata), .irq_o (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    // Caller is at a negedge; returns at the following negedge.
    task automatic cfg_write(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        wr = 1'b1; addr = a; be = b; wdata = d;
        @(negedge clk);
        wr = 1'b0; be = 4'h0; wdata = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic expect_state(input string tag, input logic [31:0] e50,
                                input logic [31:0] e54, input logic [31:0] e70, input logic ei);
        logic [31:0] d;
        rd(8'h50, d); chk({tag, " dword50"}, d, e50);
        rd(8'h54, d); chk({tag, " dword54"}, d, e54);
        rd(8'h70, d); chk({tag, " dword70"}, d, e70);
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, ei});
    endtask

    task automatic t_reset();
        expect_state("R1 R12 reset", 32'h0000_0C00, 32'h0, 32'h0, 1'b0);
    endtask

    task automatic t_rise();
        req[0] = 1'b1; cyc();
        expect_state("R2 R7 rise ch0", 32'h0000_0C04, 32'h0, 32'h0000_0400, 1'b1);
        req[1] = 1'b1; cyc();
        expect_state("R2 rise ch1", 32'h0000_0C04, 32'h1000_0000, 32'h0000_0C00, 1'b1);
    endtask

    task automatic t_alias_clear();
        cfg_write(8'h50, 4'b0001, 32'h0000_0004);
        expect_state("R4 alias clr ch0", 32'h0000_0C00, 32'h1000_0000, 32'h0000_0800, 1'b1);
        cfg_write(8'h54, 4'b1000, 32'h1000_0000);
        expect_state("R4 alias clr ch1", 32'h0000_0C00, 32'h0, 32'h0, 1'b0);
        repeat (3) cyc();
        expect_state("R10 held req no reset", 32'h0000_0C00, 32'h0, 32'h0, 1'b0);
    endtask

    task automatic t_no_set();
        cfg_write(8'h70, 4'b0010, 32'h0000_0C00);
        expect_state("R6 write cannot set", 32'h0000_0C00, 32'h0, 32'h0, 1'b0);
        req = 2'b00; cyc(); req = 2'b11; cyc();
        cfg_write(8'h50, 4'b0001, 32'h0000_0000);
        expect_state("R6 zero write", 32'h0000_0C04, 32'h1000_0000, 32'h0000_0C00, 1'b1);
        cfg_write(8'h50, 4'b1110, 32'hFFFF_FFFF);
        expect_state("R6 lane off", 32'h0000_0C04, 32'h1000_0000, 32'h0000_0C00, 1'b1);
    endtask

    task automatic t_main_clear();
        cfg_write(8'h70, 4'b0010, 32'h0000_0400);
        expect_state("R5 main clr ch0", 32'h0000_0C00, 32'h1000_0000, 32'h0000_0800, 1'b1);
        cfg_write(8'h70, 4'b0010, 32'h0000_0800);
        expect_state("R5 main clr ch1", 32'h0000_0C00, 32'h0, 32'h0, 1'b0);
    endtask

    task automatic t_block();
        req = 2'b00; cyc(); req = 2'b11; cyc();
        cfg_write(8'h70, 4'b0010, 32'h0000_1000);
        expect_state("R8 block ch0", 32'h0000_0C04, 32'h1000_0000, 32'h0000_1C00, 1'b1);
        cfg_write(8'h70, 4'b0010, 32'h0000_3000);
        expect_state("R8 R7 block both", 32'h0000_0C04, 32'h1000_0000, 32'h0000_3C00, 1'b0);
        cfg_write(8'h70, 4'b0010, 32'h0000_2000);
        expect_state("R8 R7 block ch1", 32'h0000_0C04, 32'h1000_0000, 32'h0000_2C00, 1'b1);
        cfg_write(8'h70, 4'b0010, 32'h0000_0000);
        expect_state("R8 unblock", 32'h0000_0C04, 32'h1000_0000, 32'h0000_0C00, 1'b1);
    endtask

    task automatic t_fall();
        req[0] = 1'b0; cyc();
        expect_state("R3 fall ch0", 32'h0000_0C00, 32'h1000_0000, 32'h0000_0800, 1'b1);
    endtask

    task automatic t_set_wins();
        req[1] = 1'b0; cyc();
        expect_state("R3 fall ch1", 32'h0000_0C00, 32'h0, 32'h0, 1'b0);
        req[1] = 1'b1;
        cfg_write(8'h54, 4'b1000, 32'h1000_0000);
        expect_state("R9 set wins", 32'h0000_0C00, 32'h1000_0000, 32'h0000_0800, 1'b1);
    endtask

    task automatic t_ctrl_ro();
        cfg_write(8'h50, 4'b0010, 32'h0000_F300);
        expect_state("R12 ctrl read-only", 32'h0000_0C00, 32'h1000_0000, 32'h0000_0800, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_rise();
        t_alias_clear();
        t_no_set();
        t_main_clear();
        t_block();
        t_fall();
        t_set_wins();
        t_ctrl_ro();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule